// File: doc/BRIEF.md
# Reciprocal Frequency Counter Core

This block measures the frequency of an unknown digital signal. It counts two quantities over one shared window: the rising edges of the unknown signal, and the cycles of the reference clock that the block runs on. The window opens and closes on edges of the unknown signal, so both counts cover a whole number of input periods. Downstream logic computes the frequency as `f_ref * events / ref_cycles`.

A programmable gate timer sets the nominal length of the window. The window opens on the first synchronized rising edge after the gate has been loaded. It closes on the first rising edge after the gate has run out. If the input period is longer than the gate, the window lasts one input period, and the block then acts as a period meter with no mode switch. An inactivity timeout ends a measurement with a no-signal flag instead of a result. With auto-restart enabled, the edge that closes one window also opens the next, so results follow each other with no gap.

Top module: `recip_freq_meter`

## Requirements
- R1: While reset is held and on the first cycle after it, `evt_count` and `ref_count` are zero and `result_valid`, `no_signal` and `busy` are low.
- R2: A result reports in `ref_count` the reference cycles between the opening and closing synchronized rising edges. It reports in `evt_count` the rising edges in the window, counting the closing edge and not the opening one. In back-to-back operation with input period P cycles and gate length G, this gives evt = floor(G/P)+1 and ref = P*evt.
- R3: The gate expires G reference cycles after it is loaded, and G=0 means it expires at once. The closing edge is the first rising edge seen after expiry.
- R4: When the input period exceeds the gate, each window spans exactly one input period (evt=1, ref=P).
- R5: `result_valid` is a one-cycle pulse. It is raised in the same cycle that new counts appear, and the counts hold until the next result.
- R6: With `auto_restart` high at the closing edge, that edge opens the next window and reloads the gate, so consecutive results on a steady input are identical.
- R7: With `auto_restart` low at the end of a measurement, the block goes idle (`busy` low) and produces no further result or flag until the next `start`.
- R8: A `start` pulse while `busy` is high is ignored and does not disturb the measurement in progress.
- R9: If no rising edge arrives for `timeout_len` consecutive cycles after arming or after the last edge, `no_signal` pulses for one cycle, `result_valid` stays low and the counts are unchanged. With a constantly low input, the pulse comes exactly `timeout_len` cycles after the arming edge.
- R10: An input whose period equals `timeout_len` does not time out and yields normal results.
- R11: A `start` pulse while idle arms the block, and `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Unknown signal, asynchronous to clk |
| start | input | 1 | Arms a measurement when the block is idle |
| auto_restart | input | 1 | Chains measurements without gaps when high |
| gate_len | input | GATE_W | Nominal gate length in reference cycles |
| timeout_len | input | REF_W | Cycles without an input edge before no-signal (at least 1) |
| evt_count | output | EVT_W | Latched input edge count of the last result |
| ref_count | output | REF_W | Latched reference cycle count of the last result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| no_signal | output | 1 | One-cycle strobe for a timed-out measurement |
| busy | output | 1 | A measurement is armed or in progress |

## Verification
A wrong controller state shows at the ports as counts that break the closed-form evt/ref relation for a steady input, within the second or third result after arming. A gate reloaded at the wrong moment shifts the closing edge by whole input periods, so ref moves by a multiple of P. A faulty inactivity counter shows as a `no_signal` pulse off by a cycle from the `timeout_len` arming edge, or as a spurious timeout when the period equals the limit. A leaking restart shows as strobes after `auto_restart` has been dropped, or as `busy` staying high.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_COUNT = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } rfm_state_e;

  // A measurement is armed or in progress.
  function automatic logic state_active(input rfm_state_e s);
    return (s == ST_ARMED) || (s == ST_COUNT) || (s == ST_DRAIN);
  endfunction

  // The window is open and the counters run.
  function automatic logic state_in_window(input rfm_state_e s);
    return (s == ST_COUNT) || (s == ST_DRAIN);
  endfunction

endpackage

// File: rtl/rfm_edge_sync.sv
module rfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  output logic rise
);
  // sync_q[0..STAGES-1]: metastability chain, sync_q[STAGES]: previous value
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], sig_async};
  end

  assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];

  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/rfm_gate_timer.sv
module rfm_gate_timer #(
  parameter int GATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [GATE_W-1:0] len,
  output logic              done
);
  logic [GATE_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (load)             remain_q <= len;
    else if (remain_q != '0)   remain_q <= remain_q - GATE_W'(1);
  end

  assign done = (remain_q == '0);

  // R3: once expired, the gate stays expired until reloaded
  a_r3_gate_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done);

endmodule

// File: rtl/rfm_window_ctrl.sv
module rfm_window_ctrl
  import rfm_pkg::*;
#(
  parameter int REF_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             auto_restart,
  input  logic             rise,
  input  logic             gate_done,
  input  logic [REF_W-1:0] timeout_len,
  output logic             gate_load,
  output logic             win_open,
  output logic             win_stop,
  output logic             timeout_hit,
  output logic             in_window,
  output logic             busy
);
  rfm_state_e       state_q, state_d;
  logic [REF_W-1:0] quiet_q;
  logic             tmo_due;
  logic             win_start;

  assign busy      = state_active(state_q);
  assign in_window = state_in_window(state_q);
  assign tmo_due   = busy && !rise && (quiet_q == timeout_len - REF_W'(1));
  assign win_open  = win_start || (win_stop && auto_restart);

  always_comb begin
    state_d     = state_q;
    gate_load   = 1'b0;
    win_start   = 1'b0;
    win_stop    = 1'b0;
    timeout_hit = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d   = ST_ARMED;
          gate_load = 1'b1;
        end
      end
      ST_ARMED: begin
        if (tmo_due) begin
          timeout_hit = 1'b1;
          gate_load   = auto_restart;
          state_d     = auto_restart ? ST_ARMED : ST_DONE;
        end else if (rise) begin
          win_start = 1'b1;
          state_d   = gate_done ? ST_DRAIN : ST_COUNT;
        end
      end
      ST_COUNT, ST_DRAIN: begin
        if (tmo_due) begin
          timeout_hit = 1'b1;
          gate_load   = auto_restart;
          state_d     = auto_restart ? ST_ARMED : ST_DONE;
        end else if (rise && gate_done) begin
          win_stop  = 1'b1;
          gate_load = auto_restart;
          state_d   = auto_restart ? ST_COUNT : ST_DONE;
        end else if (gate_done) begin
          state_d = ST_DRAIN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      quiet_q <= '0;
    end else begin
      state_q <= state_d;
      if (rise || gate_load) quiet_q <= '0;
      else if (busy)         quiet_q <= quiet_q + REF_W'(1);
    end
  end

  // R3: the draining state is only reachable with the gate expired
  a_r3_drain_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> gate_done);

  // R11: start while idle arms the block
  a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
  import rfm_pkg::*;
#(
  parameter int EVT_W       = 16,
  parameter int REF_W       = 24,
  parameter int GATE_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              start,
  input  logic              auto_restart,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [REF_W-1:0]  timeout_len,
  output logic [EVT_W-1:0]  evt_count,
  output logic [REF_W-1:0]  ref_count,
  output logic              result_valid,
  output logic              no_signal,
  output logic              busy
);
  logic             sig_rise;
  logic             gate_load, gate_done;
  logic             win_open, win_stop, timeout_hit, in_window;
  logic [EVT_W-1:0] evt_run_q;
  logic [REF_W-1:0] ref_run_q;

  rfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_async (sig_in),
    .rise      (sig_rise)
  );

  rfm_gate_timer #(.GATE_W(GATE_W)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (gate_load),
    .len   (gate_len),
    .done  (gate_done)
  );

  rfm_window_ctrl #(.REF_W(REF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .auto_restart (auto_restart),
    .rise         (sig_rise),
    .gate_done    (gate_done),
    .timeout_len  (timeout_len),
    .gate_load    (gate_load),
    .win_open     (win_open),
    .win_stop     (win_stop),
    .timeout_hit  (timeout_hit),
    .in_window    (in_window),
    .busy         (busy)
  );

  // Running counters: cleared on the opening edge, advanced inside the window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_run_q <= '0;
      ref_run_q <= '0;
    end else if (win_open) begin
      evt_run_q <= '0;
      ref_run_q <= '0;
    end else if (in_window) begin
      evt_run_q <= evt_run_q + {{(EVT_W-1){1'b0}}, sig_rise};
      ref_run_q <= ref_run_q + REF_W'(1);
    end
  end

  // Result registers: the closing edge and its cycle are included
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_count    <= '0;
      ref_count    <= '0;
      result_valid <= 1'b0;
      no_signal    <= 1'b0;
    end else begin
      result_valid <= win_stop;
      no_signal    <= timeout_hit;
      if (win_stop) begin
        evt_count <= evt_run_q + EVT_W'(1);
        ref_count <= ref_run_q + REF_W'(1);
      end
    end
  end

  // R5: result strobe lasts one cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R9: a timeout leaves the published counts untouched
  a_r9_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    no_signal |-> ($stable(evt_count) && $stable(ref_count)));

  // R2: every input period spans at least two reference cycles
  a_r2_ref_covers_evt: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (evt_count != '0) && (32'(ref_count) >= 2 * 32'(evt_count)));

endmodule

// File: tb/recip_freq_meter_test.sv
`timescale 1ns/1ps
module recip_freq_meter_test;

  localparam int EVT_W  = 16;
  localparam int REF_W  = 24;
  localparam int GATE_W = 20;

  // columns: period, high cycles, gate, timeout, expected evt, expected ref
  localparam int NV = 8;
  localparam int VEC [NV][6] = '{
    '{10,  5,  35, 1000,  4,  40},
    '{ 7,  3,   7, 1000,  2,  14},
    '{16,  8,   5, 1000,  1,  16},
    '{ 4,  2,  50, 1000, 13,  52},
    '{ 3,  1,   0, 1000,  1,   3},
    '{25, 12, 100, 1000,  5, 125},
    '{ 2,  1,   9, 1000,  5,  10},
    '{30, 10,  10,   30,  1,  30}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sig_in = 1'b0;
  logic              start = 1'b0;
  logic              auto_restart = 1'b0;
  logic [GATE_W-1:0] gate_len = '0;
  logic [REF_W-1:0]  timeout_len = REF_W'(1000);
  logic [EVT_W-1:0]  evt_count;
  logic [REF_W-1:0]  ref_count;
  logic              result_valid, no_signal, busy;

  int checks = 0;
  int failures = 0;
  int gen_en = 0, gen_per = 10, gen_hi = 5, phase = 0;
  int rv_seen = 0, ns_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  recip_freq_meter #(.EVT_W(EVT_W), .REF_W(REF_W), .GATE_W(GATE_W)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
    .auto_restart(auto_restart), .gate_len(gate_len), .timeout_len(timeout_len),
    .evt_count(evt_count), .ref_count(ref_count), .result_valid(result_valid),
    .no_signal(no_signal), .busy(busy)
  );

  // stimulus waveform generator and strobe monitors
  always @(negedge clk) begin
    if (gen_en == 0) begin
      sig_in = 1'b0;
      phase  = 0;
    end else begin
      sig_in = (phase < gen_hi);
      phase  = (phase + 1 >= gen_per) ? 0 : phase + 1;
    end
    if (result_valid) rv_seen++;
    if (no_signal)    ns_seen++;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_result(input string req, output bit got);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (result_valid) begin got = 1'b1; break; end
    end
    if (!got) chk({req, " result arrives"}, 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    bit got;
    longint e0, r0;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 evt_count in reset", evt_count, 0);
    chk("R1 ref_count in reset", ref_count, 0);
    chk("R1 strobes in reset", {result_valid, no_signal, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 counts after reset", evt_count + ref_count, 0);

    // vector table: steady inputs, back-to-back measurements
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (v == 2) ? "R4" : (v == 7) ? "R10" : (v == 4) ? "R3" : "R2";
      auto_restart = 1'b0;
      wait_idle();
      gen_per = VEC[v][0];
      gen_hi  = VEC[v][1];
      gen_en  = 1;
      gate_len    = GATE_W'(VEC[v][2]);
      timeout_len = REF_W'(VEC[v][3]);
      repeat (40) @(negedge clk);
      auto_restart = 1'b1;
      pulse_start();
      wait_result(tag, got);
      wait_result(tag, got);
      chk({tag, " evt count"}, evt_count, VEC[v][4]);
      chk({tag, " ref count"}, ref_count, VEC[v][5]);
      @(negedge clk);
      chk("R5 strobe one cycle", result_valid, 0);
      chk("R5 counts held", ref_count, VEC[v][5]);
      if (v == 5) begin
        repeat (30) @(negedge clk);
        pulse_start();  // R8: ignored while busy
      end
      wait_result(tag, got);
      chk(v == 5 ? "R8 evt after start while busy" : "R6 gapless evt repeat", evt_count, VEC[v][4]);
      chk(v == 5 ? "R8 ref after start while busy" : "R6 gapless ref repeat", ref_count, VEC[v][5]);
      if (v == 7) chk("R10 no timeout at equal period", ns_seen, 0);
    end

    // R7: dropping auto-restart ends after the current measurement
    auto_restart = 1'b0;
    wait_result("R7", got);
    repeat (5) @(negedge clk);
    chk("R7 idle after last result", busy, 0);
    e0 = rv_seen;
    repeat (300) @(negedge clk);
    chk("R7 no result while idle", rv_seen, e0);
    chk("R7 still idle", busy, 0);

    // R9/R11: constant low input, exact timeout position
    gen_en = 0;
    timeout_len = REF_W'(20);
    gate_len = GATE_W'(5);
    repeat (10) @(negedge clk);
    e0 = evt_count;
    r0 = ref_count;
    @(negedge clk) start = 1'b1;
    @(posedge clk);              // arming edge
    @(negedge clk) start = 1'b0;
    chk("R11 busy after start", busy, 1);
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 19) chk("R9 no flag one cycle early", no_signal, 0);
      if (i == 20) begin
        chk("R9 flag at timeout_len", no_signal, 1);
        chk("R9 no result on timeout", result_valid, 0);
        chk("R9 evt unchanged", evt_count, e0);
        chk("R9 ref unchanged", ref_count, r0);
      end
    end
    @(negedge clk);
    chk("R9 flag is one cycle", no_signal, 0);
    chk("R9 idle after timeout", busy, 0);

    // R9: slow input whose period exceeds the timeout
    gen_per = 40; gen_hi = 10; gen_en = 1;
    timeout_len = REF_W'(30);
    repeat (50) @(negedge clk);
    e0 = ns_seen;
    r0 = rv_seen;
    pulse_start();
    repeat (300) @(negedge clk);
    chk("R9 slow input flagged", (ns_seen > e0) ? 1 : 0, 1);
    chk("R9 slow input gives no result", rv_seen, r0);

    summary();
    $finish;
  end

endmodule